// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register file of a single DMA channel. A processor reaches it over a small register bus that carries an address, a write enable, a size code, write data and read data. The bank holds the descriptor and buffer pointers, the channel configuration, the two-dimensional count and stride values, the current-progress registers, an interrupt status word and a peripheral-routing word. The transfer engine sits outside. It reads the exported values, receives a start or stop strobe whenever software writes the configuration word, and reports its progress back through a load port and two status events.

While the channel is running, the bank keeps its set-up fixed. Pointer, count, stride, current-state and routing writes are dropped, and only the configuration and status words remain writable. Status flags for completion and error clear when software writes a one to them. One routing bit records the channel's type and cannot be changed by software.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every offset reads as zero, except the routing word at 0x2C, which reads the parameter PMAP_RST (default 0x0045). Both strobes and `chan_run` are low.
- R2: A 32-bit write followed by a 32-bit read returns the written value at these offsets: next descriptor 0x00, start address 0x04, current descriptor 0x20 and current address 0x24 (all 32 bits); X count 0x10, X stride 0x14, Y count 0x18, Y stride 0x1C, current X 0x30 and current Y 0x38 (low 16 bits only, upper half reads 0). The X count value also appears on `xcnt_q`.
- R3: `bus_size` encodes 0 = byte, 1 = 16-bit, 2 = 32-bit and 3 = illegal. A 16-bit access needs address bit 0 clear and a 32-bit access needs address bits 1:0 clear. Any other access raises `bus_bad` in the same cycle, changes no register and reads 0.
- R4: A 16-bit access takes its data on `bus_wdata[15:0]`. Address bit 1 picks the upper half of a 32-bit register. For a 16-bit register an upper-half write has no effect and an upper-half read returns 0. A 16-bit read returns the chosen half zero-extended.
- R5: Offsets 0x0C, 0x34 and 0x3C are reserved. They read as 0 without error, and a write to them raises `bus_bad` and changes nothing.
- R6: While RUN is set, writes to every pointer, count, stride, current-state and routing register are discarded without error.
- R7: A legal write to the config word at 0x08 stores it on `cfg_q`. If bit 0 of the new value is 1, RUN is set and `start_stb` is high for the one cycle after the write edge. If bit 0 is 0, RUN is cleared and `stop_stb` pulses the same way. A write to the upper half at 0x0A has no effect.
- R8: The status word at 0x28 has DONE at bit 0, ERR at bit 1 and RUN at bit 3. Writing 1 to DONE or ERR clears that bit. Writing 0 leaves it unchanged. RUN cannot be written through this word.
- R9: Bit CTYPE_BIT (default 6) of the routing word is read-only. A write updates only the other bits.
- R10: `eng_upd` loads the four current-state registers, even while the channel runs. `eng_done` clears RUN and sets DONE, and `eng_err` sets ERR. An engine set wins over a same-cycle clear from software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code |
| bus_addr | input | 6 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the request |
| bus_bad | output | 1 | Invalid access flag, in the cycle of the request |
| eng_upd | input | 1 | Engine loads current-state registers |
| eng_cdesc | input | PTR_W | Current descriptor value from the engine |
| eng_caddr | input | PTR_W | Current address value from the engine |
| eng_cx | input | 16 | Current X count from the engine |
| eng_cy | input | 16 | Current Y count from the engine |
| eng_done | input | 1 | Engine finished the work |
| eng_err | input | 1 | Engine detected an error |
| start_stb | output | 1 | One-cycle start request to the engine |
| stop_stb | output | 1 | One-cycle stop request to the engine |
| chan_run | output | 1 | RUN status bit |
| cfg_q | output | 16 | Configuration word |
| ndesc_q | output | PTR_W | Next descriptor pointer |
| saddr_q | output | PTR_W | Start address |
| xcnt_q | output | 16 | X count |
| xmod_q | output | 16 | X stride |
| ycnt_q | output | 16 | Y count |
| ymod_q | output | 16 | Y stride |
| pmap_q | output | 16 | Routing word |

## Verification
Read data and `bus_bad` are combinational, so the bench drives a request just after a falling edge and samples one nanosecond later, before any rising edge. Register writes, engine loads and status events take effect at the next rising edge, so their effect is read back at the following falling edge or later. The start and stop strobes are registered at the write edge. The bench samples them at the falling edge that follows, and one cycle later it checks that they have dropped again.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   // slot index = byte offset / 4
   localparam logic [3:0] S_NDESC = 4'd0;
   localparam logic [3:0] S_SADDR = 4'd1;
   localparam logic [3:0] S_CFG   = 4'd2;
   localparam logic [3:0] S_XCNT  = 4'd4;
   localparam logic [3:0] S_XMOD  = 4'd5;
   localparam logic [3:0] S_YCNT  = 4'd6;
   localparam logic [3:0] S_YMOD  = 4'd7;
   localparam logic [3:0] S_CDESC = 4'd8;
   localparam logic [3:0] S_CADDR = 4'd9;
   localparam logic [3:0] S_STAT  = 4'd10;
   localparam logic [3:0] S_PMAP  = 4'd11;
   localparam logic [3:0] S_CXCNT = 4'd12;
   localparam logic [3:0] S_CYCNT = 4'd14;

   localparam int CFG_EN_BIT   = 0;
   localparam int ST_DONE_BIT  = 0;
   localparam int ST_ERR_BIT   = 1;
   localparam int ST_RUN_BIT   = 3;
endpackage

// File: rtl/dma_acc_dec.sv
module dma_acc_dec
   import dma_regs_pkg::*;
(
   input  logic       sel,
   input  logic       we,
   input  logic [1:0] size,
   input  logic [5:0] addr,
   output logic [3:0] idx,
   output logic       hi,
   output logic       wide,
   output logic       wr_ok,
   output logic       rd_ok,
   output logic       bad
);
   logic half, legal, rsv;

   always_comb begin
      half  = (size == SZ_HALF);
      wide  = (size == SZ_WORD);
      legal = (half && !addr[0]) || (wide && (addr[1:0] == 2'b00));
      idx   = addr[5:2];
      hi    = half && addr[1];
      rsv   = (idx == 4'd3) || (idx == 4'd13) || (idx == 4'd15);
      bad   = sel && (!legal || (we && rsv));
      wr_ok = sel && we && legal && !rsv;
      rd_ok = sel && !we && legal;
   end
endmodule

// File: rtl/dma_reg_slot.sv
module dma_reg_slot #(
   parameter int           W   = 16,
   parameter logic [W-1:0] RST = '0,
   parameter logic [W-1:0] RO  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic         hi,
   input  logic         wide,
   input  logic [31:0]  wd,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q
);
   logic [W-1:0] wv;

   if (W < 16 || W > 32) begin : g_bad_w
      $error("dma_reg_slot: W must lie in 16..32");
   end

   if (W > 16) begin : g_wide
      always_comb begin
         wv = q;
         if (wide)     wv = wd[W-1:0];
         else if (hi)  wv[W-1:16] = wd[W-17:0];
         else          wv[15:0] = wd[15:0];
      end
   end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^wd[31:W];
      always_comb begin
         wv = q;
         if (wide || !hi) wv = wd[W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= RST;
      else if (ld)   q <= ld_val;
      else if (wr)   q <= (q & RO) | (wv & ~RO);
   end
endmodule

// File: rtl/dma_ctl_stat.sv
module dma_ctl_stat
   import dma_regs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic        stat_wr,
   input  logic        hi,
   input  logic [15:0] wd,
   input  logic        eng_done,
   input  logic        eng_err,
   output logic [15:0] cfg,
   output logic [15:0] stat,
   output logic        run,
   output logic        start_stb,
   output logic        stop_stb
);
   logic done_q, err_q, cfg_hit, stat_hit;

   assign cfg_hit  = cfg_wr && !hi;
   assign stat_hit = stat_wr && !hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg       <= '0;
         run       <= 1'b0;
         start_stb <= 1'b0;
         stop_stb  <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         start_stb <= 1'b0;
         stop_stb  <= 1'b0;
         if (cfg_hit) begin
            cfg <= wd;
            if (wd[CFG_EN_BIT]) begin
               run       <= 1'b1;
               start_stb <= 1'b1;
            end else begin
               run      <= 1'b0;
               stop_stb <= 1'b1;
            end
         end else if (eng_done) begin
            run <= 1'b0;
         end
         if (eng_done)                          done_q <= 1'b1;
         else if (stat_hit && wd[ST_DONE_BIT])  done_q <= 1'b0;
         if (eng_err)                           err_q <= 1'b1;
         else if (stat_hit && wd[ST_ERR_BIT])   err_q <= 1'b0;
      end
   end

   always_comb begin
      stat              = '0;
      stat[ST_DONE_BIT] = done_q;
      stat[ST_ERR_BIT]  = err_q;
      stat[ST_RUN_BIT]  = run;
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_regs_pkg::*;
#(
   parameter int          PTR_W     = 32,
   parameter logic [15:0] PMAP_RST  = 16'h0045,
   parameter int          CTYPE_BIT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_we,
   input  logic [1:0]       bus_size,
   input  logic [5:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output logic             bus_bad,
   input  logic             eng_upd,
   input  logic [PTR_W-1:0] eng_cdesc,
   input  logic [PTR_W-1:0] eng_caddr,
   input  logic [15:0]      eng_cx,
   input  logic [15:0]      eng_cy,
   input  logic             eng_done,
   input  logic             eng_err,
   output logic             start_stb,
   output logic             stop_stb,
   output logic             chan_run,
   output logic [15:0]      cfg_q,
   output logic [PTR_W-1:0] ndesc_q,
   output logic [PTR_W-1:0] saddr_q,
   output logic [15:0]      xcnt_q,
   output logic [15:0]      xmod_q,
   output logic [15:0]      ycnt_q,
   output logic [15:0]      ymod_q,
   output logic [15:0]      pmap_q
);
   localparam int          N_SLOT  = 16;
   localparam int          N_PTR   = 4;
   localparam int          N_NAR   = 6;
   localparam logic [15:0] PMAP_RO = 16'(1) << CTYPE_BIT;
   localparam logic [3:0]  P_IDX [N_PTR] = '{S_NDESC, S_SADDR, S_CDESC, S_CADDR};
   localparam logic [3:0]  N_IDX [N_NAR] = '{S_XCNT, S_XMOD, S_YCNT, S_YMOD, S_CXCNT, S_CYCNT};

   if (PTR_W < 17 || PTR_W > 32) begin : g_bad_ptr
      $error("dma_chan_regs: PTR_W must lie in 17..32");
   end
   if (CTYPE_BIT < 0 || CTYPE_BIT > 15) begin : g_bad_ct
      $error("dma_chan_regs: CTYPE_BIT must lie in 0..15");
   end

   logic [3:0]       idx;
   logic             hi, wide, wr_ok, rd_ok, run;
   logic [15:0]      stat_q;
   logic [PTR_W-1:0] pq   [N_PTR];
   logic [PTR_W-1:0] p_ld [N_PTR];
   logic [15:0]      nq   [N_NAR];
   logic [15:0]      n_ld [N_NAR];
   logic [31:0]      rd_arr [N_SLOT];
   logic [31:0]      rsel;

   dma_acc_dec u_dec (
      .sel(bus_sel), .we(bus_we), .size(bus_size), .addr(bus_addr),
      .idx(idx), .hi(hi), .wide(wide), .wr_ok(wr_ok), .rd_ok(rd_ok), .bad(bus_bad)
   );

   dma_ctl_stat u_ctl (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(wr_ok && idx == S_CFG), .stat_wr(wr_ok && idx == S_STAT),
      .hi(hi), .wd(bus_wdata[15:0]), .eng_done(eng_done), .eng_err(eng_err),
      .cfg(cfg_q), .stat(stat_q), .run(run), .start_stb(start_stb), .stop_stb(stop_stb)
   );

   assign p_ld[0] = '0;
   assign p_ld[1] = '0;
   assign p_ld[2] = eng_cdesc;
   assign p_ld[3] = eng_caddr;
   assign n_ld[0] = '0;
   assign n_ld[1] = '0;
   assign n_ld[2] = '0;
   assign n_ld[3] = '0;
   assign n_ld[4] = eng_cx;
   assign n_ld[5] = eng_cy;

   for (genvar gi = 0; gi < N_PTR; gi++) begin : g_ptr
      dma_reg_slot #(.W(PTR_W), .RST('0), .RO('0)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .wr(wr_ok && idx == P_IDX[gi] && !run),
         .hi(hi), .wide(wide), .wd(bus_wdata),
         .ld(eng_upd && (gi >= 2)), .ld_val(p_ld[gi]), .q(pq[gi])
      );
   end

   for (genvar gi = 0; gi < N_NAR; gi++) begin : g_nar
      dma_reg_slot #(.W(16), .RST('0), .RO('0)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .wr(wr_ok && idx == N_IDX[gi] && !run),
         .hi(hi), .wide(wide), .wd(bus_wdata),
         .ld(eng_upd && (gi >= 4)), .ld_val(n_ld[gi]), .q(nq[gi])
      );
   end

   dma_reg_slot #(.W(16), .RST(PMAP_RST), .RO(PMAP_RO)) u_pmap (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_ok && idx == S_PMAP && !run),
      .hi(hi), .wide(wide), .wd(bus_wdata),
      .ld(1'b0), .ld_val(16'h0000), .q(pmap_q)
   );

   always_comb begin
      for (int k = 0; k < N_SLOT; k++) rd_arr[k] = '0;
      rd_arr[S_CFG]  = {16'h0000, cfg_q};
      rd_arr[S_STAT] = {16'h0000, stat_q};
      rd_arr[S_PMAP] = {16'h0000, pmap_q};
      for (int k = 0; k < N_PTR; k++) rd_arr[P_IDX[k]] = 32'(pq[k]);
      for (int k = 0; k < N_NAR; k++) rd_arr[N_IDX[k]] = {16'h0000, nq[k]};
      rsel = rd_arr[idx];
      if (!rd_ok)     bus_rdata = '0;
      else if (wide)  bus_rdata = rsel;
      else            bus_rdata = {16'h0000, hi ? rsel[31:16] : rsel[15:0]};
   end

   assign chan_run = run;
   assign ndesc_q  = pq[0];
   assign saddr_q  = pq[1];
   assign xcnt_q   = nq[0];
   assign xmod_q   = nq[1];
   assign ycnt_q   = nq[2];
   assign ymod_q   = nq[3];
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_sel,
   input logic        bus_we,
   input logic [1:0]  bus_size,
   input logic [5:0]  bus_addr,
   input logic [31:0] bus_wdata,
   input logic        bus_bad,
   input logic        start_stb,
   input logic        stop_stb,
   input logic        chan_run,
   input logic [15:0] xcnt_q,
   input logic [15:0] stat_q,
   input logic        eng_done,
   input logic        eng_err
);
   logic legal_sz;
   assign legal_sz = (bus_size == 2'd1) || (bus_size == 2'd2);

   // R7
   start_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == 6'h08 && legal_sz && bus_wdata[0])
      |=> (start_stb && chan_run));

   // R7
   stop_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == 6'h08 && legal_sz && !bus_wdata[0])
      |=> (stop_stb && !chan_run));

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_stb && stop_stb));

   // R3
   byte_access_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_size == 2'd0) |-> bus_bad);

   // R6
   frozen_xcnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_run && bus_sel && bus_we && bus_addr[5:2] == 4'd4) |=> $stable(xcnt_q));

   // R8
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_err && !(bus_sel && bus_we && bus_addr[5:2] == 4'd10 && bus_wdata[1]))
      |=> $stable(stat_q[1]));

   // R10
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> stat_q[0]);
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_bad(bus_bad), .start_stb(start_stb), .stop_stb(stop_stb),
   .chan_run(chan_run), .xcnt_q(xcnt_q), .stat_q(stat_q),
   .eng_done(eng_done), .eng_err(eng_err)
);

// File: tb/dma_chan_regs_tb.sv
`timescale 1ns/1ps
module dma_chan_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [1:0]  bus_size = 2'd0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_bad;
   logic        eng_upd = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
   logic [31:0] eng_cdesc = '0, eng_caddr = '0;
   logic [15:0] eng_cx = '0, eng_cy = '0;
   logic        start_stb, stop_stb, chan_run;
   logic [15:0] cfg_q, xcnt_q, xmod_q, ycnt_q, ymod_q, pmap_q;
   logic [31:0] ndesc_q, saddr_q;

   int n_vec = 0, n_bad = 0;
   logic last_bad, last_start, last_stop;
   logic [31:0] m [16];
   logic [31:0] v;
   int lst [11] = '{0, 1, 4, 5, 6, 7, 8, 9, 11, 12, 14};

   always #10 clk = ~clk;

   dma_chan_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_bad(bus_bad), .eng_upd(eng_upd),
      .eng_cdesc(eng_cdesc), .eng_caddr(eng_caddr), .eng_cx(eng_cx), .eng_cy(eng_cy),
      .eng_done(eng_done), .eng_err(eng_err), .start_stb(start_stb),
      .stop_stb(stop_stb), .chan_run(chan_run), .cfg_q(cfg_q),
      .ndesc_q(ndesc_q), .saddr_q(saddr_q), .xcnt_q(xcnt_q), .xmod_q(xmod_q),
      .ycnt_q(ycnt_q), .ymod_q(ymod_q), .pmap_q(pmap_q)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
      #1 last_bad = bus_bad;
      @(negedge clk);
      last_start = start_stb; last_stop = stop_stb;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, input logic [1:0] sz, output logic [31:0] r);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
      #1 r = bus_rdata; last_bad = bus_bad;
      bus_sel = 1'b0;
   endtask

   function automatic logic [31:0] pat(input int k);
      return {8'(k * 17 + 3), 8'(k * 5 + 0), 8'(k * 29 + 1), 8'(k * 11 + 7)};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state of all offsets
      for (int k = 0; k < 16; k++) begin
         m[k] = (k == 11) ? 32'h0000_0045 : 32'h0;
         rd(6'(k * 4), 2'd2, v);
         chk("R1", "reset read", v, m[k]);
      end
      chk("R1", "strobes/run", {29'h0, start_stb, stop_stb, chan_run}, 32'h0);

      // R2 and R9 write/read-back sweep
      foreach (lst[i]) begin
         int k = lst[i];
         logic [31:0] p = pat(k);
         wr(6'(k * 4), 2'd2, p);
         if (k == 0 || k == 1 || k == 8 || k == 9) m[k] = p;
         else if (k == 11) m[k] = {16'h0, (p[15:0] & ~16'h0040) | 16'h0040};
         else m[k] = {16'h0, p[15:0]};
      end
      for (int k = 0; k < 16; k++) begin
         rd(6'(k * 4), 2'd2, v);
         chk("R2", "readback", v, m[k]);
      end
      chk("R2", "xcnt_q port", {16'h0, xcnt_q}, m[4]);

      // R4 half accesses
      wr(6'h04, 2'd1, 32'h0000_1234);
      wr(6'h06, 2'd1, 32'h0000_BEEF);
      m[1] = 32'hBEEF_1234;
      rd(6'h04, 2'd2, v); chk("R4", "halves joined", v, m[1]);
      rd(6'h06, 2'd1, v); chk("R4", "upper half read", v, 32'h0000_BEEF);
      rd(6'h04, 2'd1, v); chk("R4", "lower half read", v, 32'h0000_1234);
      wr(6'h12, 2'd1, 32'h0000_7777);
      chk("R4", "upper half of 16-bit reg accepted", {31'h0, last_bad}, 32'h0);
      rd(6'h10, 2'd2, v); chk("R4", "16-bit reg unchanged", v, m[4]);
      rd(6'h12, 2'd1, v); chk("R4", "16-bit reg upper read", v, 32'h0);

      // R3 illegal sizes and alignment
      wr(6'h00, 2'd0, 32'hFFFF_FFFF); chk("R3", "byte write bad", {31'h0, last_bad}, 32'h1);
      wr(6'h06, 2'd2, 32'hFFFF_FFFF); chk("R3", "misaligned word bad", {31'h0, last_bad}, 32'h1);
      wr(6'h10, 2'd3, 32'hFFFF_FFFF); chk("R3", "size 3 bad", {31'h0, last_bad}, 32'h1);
      wr(6'h11, 2'd1, 32'hFFFF_FFFF); chk("R3", "odd half bad", {31'h0, last_bad}, 32'h1);
      rd(6'h00, 2'd2, v); chk("R3", "no effect ndesc", v, m[0]);
      rd(6'h04, 2'd2, v); chk("R3", "no effect saddr", v, m[1]);
      rd(6'h10, 2'd2, v); chk("R3", "no effect xcnt", v, m[4]);
      rd(6'h00, 2'd0, v); chk("R3", "byte read data", v, 32'h0);
      chk("R3", "byte read bad", {31'h0, last_bad}, 32'h1);

      // R5 reserved offsets
      wr(6'h0C, 2'd2, 32'h1234_5678); chk("R5", "reserved write bad", {31'h0, last_bad}, 32'h1);
      rd(6'h0C, 2'd2, v); chk("R5", "reserved read", v, 32'h0);
      chk("R5", "reserved read ok", {31'h0, last_bad}, 32'h0);
      wr(6'h34, 2'd1, 32'h0000_5678); chk("R5", "reserved half write bad", {31'h0, last_bad}, 32'h1);
      rd(6'h3C, 2'd1, v); chk("R5", "reserved half read", v, 32'h0);

      // R7 start
      wr(6'h08, 2'd2, 32'h0000_A5B1);
      chk("R7", "start strobe", {30'h0, last_start, last_stop}, 32'h2);
      chk("R7", "cfg_q", {16'h0, cfg_q}, 32'h0000_A5B1);
      @(negedge clk);
      chk("R7", "start strobe drops", {31'h0, start_stb}, 32'h0);
      rd(6'h28, 2'd2, v); chk("R7", "RUN set", v, 32'h8);

      // R6 frozen while running
      foreach (lst[i]) wr(6'(lst[i] * 4), 2'd2, 32'hFFFF_FFFF);
      wr(6'h00, 2'd1, 32'h0000_0000);
      wr(6'h26, 2'd1, 32'h0000_0000);
      foreach (lst[i]) begin
         rd(6'(lst[i] * 4), 2'd2, v);
         chk("R6", "frozen readback", v, m[lst[i]]);
      end

      // R10 engine loads while running
      @(negedge clk);
      eng_upd = 1'b1; eng_cdesc = 32'h1111_2220; eng_caddr = 32'h3333_4440;
      eng_cx = 16'h0007; eng_cy = 16'h0003;
      @(negedge clk);
      eng_upd = 1'b0;
      rd(6'h20, 2'd2, v); chk("R10", "cdesc load", v, 32'h1111_2220);
      rd(6'h24, 2'd2, v); chk("R10", "caddr load", v, 32'h3333_4440);
      rd(6'h30, 2'd2, v); chk("R10", "cx load", v, 32'h7);
      rd(6'h38, 2'd2, v); chk("R10", "cy load", v, 32'h3);
      @(negedge clk); eng_err = 1'b1; @(negedge clk); eng_err = 1'b0;
      rd(6'h28, 2'd2, v); chk("R10", "ERR set", v, 32'hA);
      @(negedge clk); eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
      rd(6'h28, 2'd2, v); chk("R10", "DONE set RUN clr", v, 32'h3);
      chk("R10", "chan_run low", {31'h0, chan_run}, 32'h0);

      // R8 write-one-to-clear
      wr(6'h28, 2'd2, 32'h0000_FFFC); rd(6'h28, 2'd2, v); chk("R8", "zeros keep", v, 32'h3);
      wr(6'h28, 2'd1, 32'h0000_0001); rd(6'h28, 2'd2, v); chk("R8", "DONE cleared", v, 32'h2);
      wr(6'h28, 2'd2, 32'h0000_0002); rd(6'h28, 2'd2, v); chk("R8", "ERR cleared", v, 32'h0);

      // R10 engine set beats software clear
      @(negedge clk);
      eng_err = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h28;
      bus_size = 2'd2; bus_wdata = 32'h2;
      @(negedge clk);
      eng_err = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
      rd(6'h28, 2'd2, v); chk("R10", "set wins", v, 32'h2);

      // R7 stop and upper-half config write
      wr(6'h08, 2'd2, 32'h0000_0001);
      wr(6'h08, 2'd1, 32'h0000_0000);
      chk("R7", "stop strobe", {30'h0, last_start, last_stop}, 32'h1);
      rd(6'h28, 2'd2, v); chk("R7", "RUN cleared", v, 32'h2);
      wr(6'h0A, 2'd1, 32'h0000_0001);
      chk("R7", "upper cfg no strobe", {30'h0, last_start, last_stop}, 32'h0);
      rd(6'h08, 2'd2, v); chk("R7", "cfg unchanged", v, 32'h0);

      // R9 read-only channel-type bit
      wr(6'h2C, 2'd2, 32'h0);
      rd(6'h2C, 2'd2, v); chk("R9", "ctype kept", v, 32'h0000_0040);
      wr(6'h2C, 2'd1, 32'h0000_FFBF);
      rd(6'h2C, 2'd2, v); chk("R9", "others written", v, 32'h0000_FFFF);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule